// File: doc/BRIEF.md
# Two-Level Interrupt Autovector Unit

This block gathers a group of interrupt request sources that share a single processor interrupt line. Each source delivers a one-cycle event pulse that is held in a pending bit until firmware clears it. Pending bits are gated by per-source enables, and the enabled pending bits are ORed onto one interrupt line. A fixed-priority encoder picks the winning source. Its slot index, multiplied by four, is the vector byte.

When the processor takes the interrupt it fetches a three-byte jump at a fixed address. The opcode byte and the page byte come unchanged from memory. The fetch of the low address byte (jump address + 2) is intercepted: if autovectoring is on, the captured vector byte replaces the memory data, and firmware lands directly in the right entry of a jump table. The same unit serves a 32-slot USB event group at its default parameters. A 16-slot FIFO/interface group uses `SLOTS = 16`, giving vectors 0x00 to 0x3C.

Top module: `avecUnit`

## Requirements
- R1: A pulse on `srcPulse[i]` for an active slot sets that slot's pending bit at the next clock edge. If `srcEnable[i]` is 1, `irqOut` is 1 from that edge on.
- R2: Reserved slots (indices 5, 7, 16, 24 and 25 in the default 32-slot group) never become pending. A pulse on a reserved slot raises no interrupt and never appears as a vector.
- R3: A pending slot whose enable is 0 neither drives `irqOut` nor takes part in priority. Setting its enable later makes it count, with no new pulse.
- R4: A cycle with `clrWrite` = 1 clears every pending bit whose `clrMask` bit is 1 and leaves the other bits unchanged. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R5: The lowest-numbered enabled pending slot wins. The vector byte is 4 × slot index, with bits [1:0] always 0.
- R6: A fetch is an address cycle (`fetchValid` = 1, `fetchAddr`) followed by a data cycle. If the address is jump address + 2 (0x0045 by default) and `avEnable` was 1 in the address cycle, then `fetchData` in the data cycle is the vector byte.
- R7: In every other data cycle `fetchData` equals `memData`. This covers `avEnable` = 0, the opcode at 0x0043 and the page byte at 0x0044.
- R8: The vector byte is taken in the address cycle. A request that arrives in that same cycle does not change the byte that is returned.
- R9: If autovectoring is on and no enabled slot is pending, the substituted byte is 0x00.
- R10: After reset all pending bits are 0, `irqOut` is 0 and `fetchData` follows `memData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | SLOTS | One-cycle event pulses, one per slot |
| srcEnable | input | SLOTS | Per-slot interrupt enables |
| clrWrite | input | 1 | Firmware clear write strobe |
| clrMask | input | SLOTS | Write-1-to-clear data for the clear write |
| avEnable | input | 1 | Autovector substitution enable |
| fetchValid | input | 1 | Code fetch address cycle |
| fetchAddr | input | ADDR_W | Code fetch address |
| memData | input | 8 | Code memory data for the data cycle |
| fetchData | output | 8 | Data returned to the processor in the data cycle |
| irqOut | output | 1 | Shared interrupt line to the processor |

## Verification
A pulse or clear applied at a falling edge changes the pending state at the next rising edge. The bench therefore reads `irqOut` at the following falling edge, one cycle after the stimulus. A fetch returns its byte one cycle after the address cycle, and the bench reads `fetchData` 1 ns after the falling edge that starts the data cycle, once `memData` has been driven. The capture test puts a new pulse into the address cycle itself and checks that only the next fetch sees it.

// File: rtl/avecPkg.sv
package avecPkg;
  // strobes issued by control toward the datapath
  typedef struct packed {
    logic capture;  // latch vector byte for substitution
    logic clear;    // apply firmware write-1-to-clear
  } avecStrobe_t;
endpackage

// File: rtl/avecControl.sv
module avecControl
  import avecPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0045
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              avEnable,
  input  logic              clrWrite,
  output avecStrobe_t       strobe,
  output logic              overrideQ
);
  logic hitVec;

  assign hitVec = fetchValid && (fetchAddr == VEC_ADDR) && avEnable;

  always_comb begin
    strobe.capture = hitVec;
    strobe.clear   = clrWrite;
  end

  // data phase of an intercepted fetch follows its address phase
  always_ff @(posedge clk) begin
    if (!rstN) overrideQ <= 1'b0;
    else       overrideQ <= hitVec;
  end
endmodule

// File: rtl/avecDatapath.sv
module avecDatapath
  import avecPkg::*;
#(
  parameter int SLOTS = 32,
  parameter logic [SLOTS-1:0] ACTIVE_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  avecStrobe_t      strobe,
  input  logic [SLOTS-1:0] srcPulse,
  input  logic [SLOTS-1:0] srcEnable,
  input  logic [SLOTS-1:0] clrMask,
  output logic             irqOut,
  output logic [7:0]       vecNow,
  output logic [7:0]       vecQ
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] pendingQ;
  logic [SLOTS-1:0] liveReq;
  logic [IDX_W-1:0] winIdx;
  logic             anyLive;

  // pending bits: a set in the same cycle beats a clear
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (ACTIVE_MASK[g]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rstN) pendingQ[g] <= 1'b0;
        else       pendingQ[g] <= srcPulse[g] |
                                  (pendingQ[g] & ~(strobe.clear & clrMask[g]));
      end
    end else begin : g_rsvd
      assign pendingQ[g] = 1'b0;
    end
  end

  assign liveReq = pendingQ & srcEnable;
  assign anyLive = |liveReq;
  assign irqOut  = anyLive;

  // fixed priority: lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (liveReq[i]) winIdx = IDX_W'(i);
    end
  end

  assign vecNow = anyLive ? (8'(winIdx) << 2) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN)              vecQ <= 8'h00;
    else if (strobe.capture) vecQ <= vecNow;
  end
endmodule

// File: rtl/avecUnit.sv
module avecUnit
  import avecPkg::*;
#(
  parameter int SLOTS = 32,
  parameter logic [SLOTS-1:0] ACTIVE_MASK = 32'hFCFE_FF5F,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] JUMP_ADDR = 16'h0043
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOTS-1:0]  srcPulse,
  input  logic [SLOTS-1:0]  srcEnable,
  input  logic              clrWrite,
  input  logic [SLOTS-1:0]  clrMask,
  input  logic              avEnable,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [7:0]        memData,
  output logic [7:0]        fetchData,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = JUMP_ADDR + ADDR_W'(2);

  avecStrobe_t strobe;
  logic        overrideQ;
  logic [7:0]  vecNow;
  logic [7:0]  vecQ;

  avecControl #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .avEnable(avEnable), .clrWrite(clrWrite), .strobe(strobe), .overrideQ(overrideQ)
  );

  avecDatapath #(.SLOTS(SLOTS), .ACTIVE_MASK(ACTIVE_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcPulse(srcPulse),
    .srcEnable(srcEnable), .clrMask(clrMask), .irqOut(irqOut),
    .vecNow(vecNow), .vecQ(vecQ)
  );

  assign fetchData = overrideQ ? vecQ : memData;
endmodule

// File: rtl/avecUnit_chk.sv
module avecUnit_chk #(
  parameter int SLOTS = 32,
  parameter logic [SLOTS-1:0] ACTIVE_MASK = '1,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0045
) (
  input logic              clk,
  input logic              rstN,
  input logic [SLOTS-1:0]  srcPulse,
  input logic [SLOTS-1:0]  srcEnable,
  input logic              clrWrite,
  input logic [SLOTS-1:0]  clrMask,
  input logic              avEnable,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [7:0]        memData,
  input logic [7:0]        fetchData,
  input logic              irqOut,
  input logic [7:0]        vecNow
);
  logic hitVec;
  assign hitVec = fetchValid && (fetchAddr == VEC_ADDR) && avEnable;

  AST_PULSE_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(srcPulse) & ACTIVE_MASK & srcEnable)) |-> irqOut);  // R1

  AST_CLEAR_ALL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrWrite) && ($past(clrMask) == '1) && ($past(srcPulse) == '0)) |-> !irqOut);  // R4

  AST_VEC_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $past(hitVec) |-> ((fetchData[1:0] == 2'b00) &&
                       (|(ACTIVE_MASK & (SLOTS'(1) << fetchData[7:2])))));  // R2

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(hitVec) |-> (fetchData == $past(vecNow)));  // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hitVec) |-> (fetchData == memData));  // R7
endmodule

bind avecUnit avecUnit_chk #(
  .SLOTS(SLOTS), .ACTIVE_MASK(ACTIVE_MASK), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .srcEnable(srcEnable),
  .clrWrite(clrWrite), .clrMask(clrMask), .avEnable(avEnable),
  .fetchValid(fetchValid), .fetchAddr(fetchAddr), .memData(memData),
  .fetchData(fetchData), .irqOut(irqOut), .vecNow(vecNow)
);

// File: tb/avecUnit_bench.sv
`timescale 1ns/1ps
module avecUnit_bench;
  localparam logic [31:0] ACT = 32'hFCFE_FF5F; // reserved 5,7,16,24,25

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcPulse = '0, srcEnable = '1, clrMask = '0;
  logic        clrWrite = 1'b0, avEnable = 1'b1, fetchValid = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic [7:0]  memData = '0, fetchData;
  logic        irqOut;
  int          nChk = 0, nBad = 0;
  logic [7:0]  got;

  always #10 clk = ~clk;

  avecUnit u_avecUnit (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .srcEnable(srcEnable),
    .clrWrite(clrWrite), .clrMask(clrMask), .avEnable(avEnable),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .memData(memData),
    .fetchData(fetchData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expVec(input logic [31:0] pend, input logic [31:0] en);
    for (int i = 0; i < 32; i++)
      if (pend[i] & en[i] & ACT[i]) return 8'(i * 4);
    return 8'h00;
  endfunction

  task automatic pulse(input logic [31:0] m);
    srcPulse = m; @(negedge clk); srcPulse = '0;
  endtask

  task automatic clear(input logic [31:0] m);
    clrWrite = 1'b1; clrMask = m; @(negedge clk); clrWrite = 1'b0; clrMask = '0;
  endtask

  task automatic doFetch(input logic [15:0] a, input logic [7:0] m, output logic [7:0] d);
    fetchValid = 1'b1; fetchAddr = a; @(negedge clk);
    fetchValid = 1'b0; memData = m; #1 d = fetchData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    memData = 8'h5A; #1;
    check("R10 irq after reset", {7'd0, irqOut}, 8'h00);
    check("R10 fetchData follows memData", fetchData, 8'h5A);
    doFetch(16'h0045, 8'hEE, got);
    check("R9 idle vector", got, 8'h00);

    // single-slot sweep
    for (int i = 0; i < 32; i++) begin
      clear('1);
      pulse(32'(1) << i);
      check($sformatf("R1/R2 irq slot %0d", i), {7'd0, irqOut}, {7'd0, ACT[i]});
      doFetch(16'h0045, 8'hEE, got);
      check($sformatf("R5/R6 vector slot %0d", i), got, ACT[i] ? 8'(i * 4) : 8'h00);
    end

    // pair sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] m;
      m = (32'(1) << i) | (32'(1) << ((i * 7 + 3) % 32));
      clear('1);
      pulse(m);
      doFetch(16'h0045, 8'hEE, got);
      check($sformatf("R5 pair %08h", m), got, expVec(m, '1));
    end

    // enable masking
    clear('1);
    srcEnable = 32'(1) << 12;
    pulse((32'(1) << 3) | (32'(1) << 12));
    doFetch(16'h0045, 8'hEE, got);
    check("R3 masked lower slot", got, 8'h30);
    srcEnable = 32'(1) << 20;
    @(negedge clk);
    check("R3 irq low when none enabled", {7'd0, irqOut}, 8'h00);
    srcEnable = '1;
    @(negedge clk);
    check("R3 irq on re-enable", {7'd0, irqOut}, 8'h01);
    doFetch(16'h0045, 8'hEE, got);
    check("R3 re-enabled wins", got, 8'h0C);

    // clears
    clear(32'(1) << 3);
    doFetch(16'h0045, 8'hEE, got);
    check("R4 selective clear", got, 8'h30);
    clear(32'(1) << 12);
    check("R4 clear last drops irq", {7'd0, irqOut}, 8'h00);
    srcPulse = 32'(1) << 4; clrWrite = 1'b1; clrMask = 32'(1) << 4;
    @(negedge clk);
    srcPulse = '0; clrWrite = 1'b0; clrMask = '0;
    check("R4 set beats clear", {7'd0, irqOut}, 8'h01);

    // pass-through cases
    avEnable = 1'b0;
    doFetch(16'h0045, 8'hA5, got);
    check("R7 av off passes memory", got, 8'hA5);
    avEnable = 1'b1;
    doFetch(16'h0044, 8'h12, got);
    check("R7 page byte unchanged", got, 8'h12);
    doFetch(16'h0043, 8'h02, got);
    check("R7 opcode unchanged", got, 8'h02);

    // capture timing
    clear('1);
    pulse(32'(1) << 10);
    fetchValid = 1'b1; fetchAddr = 16'h0045; srcPulse = 32'(1) << 2;
    @(negedge clk);
    fetchValid = 1'b0; srcPulse = '0; memData = 8'hEE; #1;
    check("R8 late request not seen", fetchData, 8'h28);
    @(negedge clk);
    doFetch(16'h0045, 8'hEE, got);
    check("R8 next fetch sees it", got, 8'h08);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule